// File: doc/BRIEF.md
# Multi-Key Hold Reset Generator

This block turns a held group of active-low keys into a system reset. A static selection code picks which leading keys form the combination. In normal running, that combination must stay low for a long qualification time, counted on a slow-clock enable. When that time is reached, the block drives a fixed-width reset pulse. After the pulse the processor may start again even while the keys are still down. A new reset is only possible after the keys have been released.

When the system is asleep, or the oscillator is still stabilising, the qualification timer is skipped. The reset then asserts as soon as the combination is seen low and stays asserted until the combination is released. Independently of all key logic, a low level on the external reset pin forces the reset at once.

Every release of the reset starts a start-up delay counted on a fast-clock enable. The CPU start enable stays low until that delay has elapsed. Both timing domains are modelled as clock enables on one clock. Keys are sampled through a two-stage synchroniser on the slow enable. The release is resynchronised by two stages on the fast enable before it is counted.

Top module: `keyhold_rst`

## Requirements
- R1: While `ext_rst_n` is low, `sys_rst` is 1 and `cpu_run` is 0, with no clock needed for `sys_rst` to assert.
- R2: `combo_sel` = 0 selects no key. A value k >= 1 selects keys 0 through k (code 1 = keys 0,1; code 2 = keys 0..2; code 3 = keys 0..3). The combination is "low" only when every selected key is low; a subset of the selected keys low is not enough.
- R3: Outside sleep and oscillator wait, the internal reset asserts on the slow tick that completes `HOLD_TICKS` consecutive slow ticks of the synchronised combination being low. Key changes reach the comparison two slow ticks after they appear on `key_n`.
- R4: A selected key seen high on any slow tick before the count completes clears the hold count, so qualification restarts from zero.
- R5: A reset from the timed path lasts exactly `PULSE_TICKS` slow ticks. After it ends, no further key reset occurs until the combination has been seen released, even if the keys stay low.
- R6: `cpu_run` rises only after the internal reset has been released, and only once the release has crossed a two-stage fast synchroniser and `START_TICKS` further fast ticks have passed. `cpu_run` falls in the same cycle that `sys_rst` asserts.
- R7: While `sleep_i` or `osc_wait_i` is 1, the reset asserts on the first slow tick that sees the combination low, with no hold time. It stays asserted until a slow tick sees the combination released.
- R8: With `combo_sel` = 0, or with only unselected keys low, no key reset is generated for any duration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock carrying both enables |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| slow_en | input | 1 | Slow-clock tick enable (qualification domain) |
| fast_en | input | 1 | Fast-clock tick enable (start-up domain) |
| key_n | input | NKEY | Key lines, active low |
| combo_sel | input | $clog2(NKEY) | Static combination code |
| sleep_i | input | 1 | Sleep status, bypasses the hold timer |
| osc_wait_i | input | 1 | Oscillator-stabilisation status, bypasses the hold timer |
| sys_rst | output | 1 | Internal system reset, active high |
| cpu_run | output | 1 | CPU start enable |

## Verification
The combination is exercised in several ways:
- Only unselected keys held, which separates the selection mask from a plain all-low check.
- All keys held under the disabled code.
- A strict subset of a three-key code held, which shows that an AND of the selected keys is required and an OR is not enough.
- A full hold that is broken by a short release and then pressed again. The measured latency from the second press separates a restarting counter from one that merely pauses.

The timed path is measured for its exact pulse width with the keys still held, and for the absence of a retrigger afterwards. The sleep and oscillator-wait bypasses are measured for near-immediate assertion and for a reset that lasts until release. An external reset is applied mid-run to show it overrides the key logic.

// File: rtl/keyhold_pkg.sv
package keyhold_pkg;
   typedef enum logic [1:0] {
      QS_ARM   = 2'd0,
      QS_PULSE = 2'd1,
      QS_HOLD  = 2'd2,
      QS_REARM = 2'd3
   } qual_state_t;
endpackage

// File: rtl/keyhold_sync.sv
module keyhold_sync #(
   parameter int           W       = 1,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stage1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage1 <= RST_VAL;
         q      <= RST_VAL;
      end else if (en) begin
         stage1 <= d;
         q      <= stage1;
      end
   end
endmodule

// File: rtl/keyhold_qual.sv
module keyhold_qual
   import keyhold_pkg::*;
#(
   parameter int NKEY        = 4,
   parameter int HOLD_TICKS  = 65536,
   parameter int PULSE_TICKS = 64,
   localparam int SELW       = $clog2(NKEY),
   localparam int MAXT       = (HOLD_TICKS > PULSE_TICKS) ? HOLD_TICKS : PULSE_TICKS,
   localparam int CNTW       = $clog2(MAXT + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick,
   input  logic [NKEY-1:0] keys_low,
   input  logic [SELW-1:0] sel,
   input  logic            bypass,
   output logic            combo_low,
   output logic            pulse_act,
   output logic            hold_act
);
   qual_state_t     state;
   logic [CNTW-1:0] cnt;
   logic [NKEY-1:0] sel_mask;

   // key i takes part when the code is non-zero and i <= code
   for (genvar i = 0; i < NKEY; i++) begin : g_mask
      assign sel_mask[i] = (sel != '0) && (SELW'(i) <= sel);
   end

   assign combo_low = (sel != '0) && (&(keys_low | ~sel_mask));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= QS_ARM;
         cnt   <= '0;
      end else if (tick) begin
         unique case (state)
            QS_ARM: begin
               if (!combo_low) begin
                  cnt <= '0;
               end else if (bypass) begin
                  state <= QS_HOLD;
                  cnt   <= '0;
               end else if (cnt == CNTW'(HOLD_TICKS - 1)) begin
                  state <= QS_PULSE;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            QS_PULSE: begin
               if (cnt == CNTW'(PULSE_TICKS - 1)) begin
                  state <= QS_REARM;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            QS_HOLD, QS_REARM: begin
               if (!combo_low) begin
                  state <= QS_ARM;
               end
               cnt <= '0;
            end
            default: begin
               state <= QS_ARM;
               cnt   <= '0;
            end
         endcase
      end
   end

   assign pulse_act = (state == QS_PULSE);
   assign hold_act  = (state == QS_HOLD);
endmodule

// File: rtl/keyhold_start.sv
module keyhold_start #(
   parameter int START_TICKS = 512,
   localparam int SCW        = $clog2(START_TICKS + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic released,
   output logic done
);
   logic           rel_s;
   logic [SCW-1:0] scnt;

   keyhold_sync #(.W(1), .RST_VAL(1'b0)) u_rel_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (tick),
      .d     (released),
      .q     (rel_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scnt <= '0;
      end else if (tick) begin
         if (!rel_s) begin
            scnt <= '0;
         end else if (scnt != SCW'(START_TICKS)) begin
            scnt <= scnt + 1'b1;
         end
      end
   end

   assign done = (scnt == SCW'(START_TICKS));
endmodule

// File: rtl/keyhold_rst.sv
module keyhold_rst #(
   parameter int NKEY        = 4,
   parameter int HOLD_TICKS  = 65536,
   parameter int PULSE_TICKS = 64,
   parameter int START_TICKS = 512
) (
   input  logic                    clk,
   input  logic                    ext_rst_n,
   input  logic                    slow_en,
   input  logic                    fast_en,
   input  logic [NKEY-1:0]         key_n,
   input  logic [$clog2(NKEY)-1:0] combo_sel,
   input  logic                    sleep_i,
   input  logic                    osc_wait_i,
   output logic                    sys_rst,
   output logic                    cpu_run
);
   if (NKEY < 2) begin : g_bad_nkey
      $error("keyhold_rst: NKEY must be at least 2");
   end
   if (HOLD_TICKS < 1 || PULSE_TICKS < 1 || START_TICKS < 1) begin : g_bad_ticks
      $error("keyhold_rst: tick counts must be at least 1");
   end

   logic [NKEY-1:0] key_s;
   logic            combo_low;
   logic            pulse_act;
   logic            hold_act;
   logic            key_rst;
   logic            start_done;

   keyhold_sync #(.W(NKEY), .RST_VAL({NKEY{1'b1}})) u_key_sync (
      .clk   (clk),
      .rst_n (ext_rst_n),
      .en    (slow_en),
      .d     (key_n),
      .q     (key_s)
   );

   keyhold_qual #(
      .NKEY        (NKEY),
      .HOLD_TICKS  (HOLD_TICKS),
      .PULSE_TICKS (PULSE_TICKS)
   ) u_qual (
      .clk       (clk),
      .rst_n     (ext_rst_n),
      .tick      (slow_en),
      .keys_low  (~key_s),
      .sel       (combo_sel),
      .bypass    (sleep_i | osc_wait_i),
      .combo_low (combo_low),
      .pulse_act (pulse_act),
      .hold_act  (hold_act)
   );

   assign key_rst = pulse_act | hold_act;

   keyhold_start #(.START_TICKS(START_TICKS)) u_start (
      .clk      (clk),
      .rst_n    (ext_rst_n),
      .tick     (fast_en),
      .released (~key_rst),
      .done     (start_done)
   );

   assign sys_rst = ~ext_rst_n | key_rst;
   assign cpu_run = start_done & ~key_rst & ext_rst_n;
endmodule

// File: rtl/keyhold_chk.sv
module keyhold_chk #(
   parameter int NKEY        = 4,
   parameter int HOLD_TICKS  = 65536,
   parameter int PULSE_TICKS = 64,
   parameter int START_TICKS = 512
) (
   input logic                    clk,
   input logic                    ext_rst_n,
   input logic                    slow_en,
   input logic                    fast_en,
   input logic [$clog2(NKEY)-1:0] combo_sel,
   input logic                    combo_low,
   input logic                    pulse_act,
   input logic                    hold_act,
   input logic                    sys_rst,
   input logic                    cpu_run
);
   logic [31:0] low_cnt;
   logic [31:0] pw_cnt;
   logic [31:0] fr_cnt;

   always_ff @(posedge clk or negedge ext_rst_n) begin
      if (!ext_rst_n) begin
         low_cnt <= '0;
         pw_cnt  <= '0;
         fr_cnt  <= '0;
      end else begin
         if (slow_en) begin
            if (!combo_low)                   low_cnt <= '0;
            else if (low_cnt <= HOLD_TICKS)   low_cnt <= low_cnt + 1;
            if (pulse_act)                    pw_cnt  <= pw_cnt + 1;
            else                              pw_cnt  <= '0;
         end
         if (sys_rst)                              fr_cnt <= '0;
         else if (fast_en && fr_cnt <= START_TICKS) fr_cnt <= fr_cnt + 1;
      end
   end

   always @(negedge clk) begin
      if (!ext_rst_n) begin
         a_r1_ext_forces: assert (sys_rst && !cpu_run);
      end
   end

   a_r3_hold_before_pulse: assert property (@(posedge clk) disable iff (!ext_rst_n)
      $rose(pulse_act) |-> (low_cnt >= HOLD_TICKS));

   a_r5_pulse_width: assert property (@(posedge clk) disable iff (!ext_rst_n)
      $fell(pulse_act) |-> (pw_cnt == PULSE_TICKS));

   a_r6_start_delay: assert property (@(posedge clk) disable iff (!ext_rst_n)
      $rose(cpu_run) |-> (fr_cnt >= START_TICKS));

   a_r6_run_off_in_reset: assert property (@(posedge clk) disable iff (!ext_rst_n)
      sys_rst |-> !cpu_run);

   a_r7_hold_until_release: assert property (@(posedge clk) disable iff (!ext_rst_n)
      (hold_act && combo_low) |=> hold_act);

   a_r8_disabled_code: assert property (@(posedge clk) disable iff (!ext_rst_n)
      (combo_sel == '0 && !pulse_act && !hold_act) |=> (!pulse_act && !hold_act));
endmodule

bind keyhold_rst keyhold_chk #(
   .NKEY        (NKEY),
   .HOLD_TICKS  (HOLD_TICKS),
   .PULSE_TICKS (PULSE_TICKS),
   .START_TICKS (START_TICKS)
) u_chk (
   .clk       (clk),
   .ext_rst_n (ext_rst_n),
   .slow_en   (slow_en),
   .fast_en   (fast_en),
   .combo_sel (combo_sel),
   .combo_low (combo_low),
   .pulse_act (pulse_act),
   .hold_act  (hold_act),
   .sys_rst   (sys_rst),
   .cpu_run   (cpu_run)
);

// File: tb/keyhold_rst_tb.sv
`timescale 1ns/1ps
module keyhold_rst_tb;
   localparam int NK  = 4;
   localparam int HT  = 40;
   localparam int PT  = 8;
   localparam int ST  = 16;
   localparam int SDV = 4;   // clocks per slow tick
   localparam int FDV = 2;   // clocks per fast tick

   logic          clk = 1'b0;
   logic          ext_rst_n = 1'b1;
   logic          slow_en = 1'b0;
   logic          fast_en = 1'b0;
   logic [NK-1:0] key_n = '1;
   logic [1:0]    combo_sel = 2'd0;
   logic          sleep_i = 1'b0;
   logic          osc_wait_i = 1'b0;
   logic          sys_rst;
   logic          cpu_run;

   int compared = 0;
   int mismatched = 0;
   int cyc = 0;
   bit cmp_on = 0;

   always #2 clk = ~clk;

   keyhold_rst #(.NKEY(NK), .HOLD_TICKS(HT), .PULSE_TICKS(PT), .START_TICKS(ST)) u_dut (
      .clk(clk), .ext_rst_n(ext_rst_n), .slow_en(slow_en), .fast_en(fast_en),
      .key_n(key_n), .combo_sel(combo_sel), .sleep_i(sleep_i), .osc_wait_i(osc_wait_i),
      .sys_rst(sys_rst), .cpu_run(cpu_run)
   );

   // tick enables
   always @(negedge clk) begin
      cyc     <= cyc + 1;
      slow_en <= ((cyc + 1) % SDV) == 0;
      fast_en <= ((cyc + 1) % FDV) == 0;
   end

   // behavioural reference
   int m_s1 = 15, m_s2 = 15, m_st = 0, m_cnt = 0, m_r1 = 0, m_r2 = 0, m_sc = 0;

   function automatic bit m_match(int s2, int sel);
      if (sel == 0) return 0;
      for (int i = 0; i <= sel; i++) if (s2[i]) return 0;
      return 1;
   endfunction

   always @(posedge clk) begin
      cmp_on <= 1;
      if (!ext_rst_n) begin
         m_s1 = 15; m_s2 = 15; m_st = 0; m_cnt = 0; m_r1 = 0; m_r2 = 0; m_sc = 0;
      end else begin
         bit krst_o, r2_o, mt;
         krst_o = (m_st == 1) || (m_st == 2);
         r2_o   = m_r2[0];
         if (fast_en) begin
            m_r2 = m_r1;
            m_r1 = !krst_o;
            if (r2_o) begin if (m_sc < ST) m_sc++; end
            else m_sc = 0;
         end
         if (slow_en) begin
            mt = m_match(m_s2, int'(combo_sel));
            m_s2 = m_s1;
            m_s1 = int'(key_n);
            case (m_st)
               0: if (!mt) m_cnt = 0;
                  else if (sleep_i || osc_wait_i) begin m_st = 2; m_cnt = 0; end
                  else if (m_cnt == HT - 1) begin m_st = 1; m_cnt = 0; end
                  else m_cnt++;
               1: if (m_cnt == PT - 1) begin m_st = 3; m_cnt = 0; end
                  else m_cnt++;
               default: begin if (!mt) m_st = 0; m_cnt = 0; end
            endcase
         end
      end
   end

   always @(negedge clk) begin
      if (cmp_on) begin
         bit e_rst, e_run;
         e_rst = !ext_rst_n || m_st == 1 || m_st == 2;
         e_run = ext_rst_n && m_sc == ST && !(m_st == 1 || m_st == 2);
         compared++;
         if (sys_rst !== e_rst || cpu_run !== e_run) begin
            mismatched++;
            $display("FAIL model compare (R1 R3 R5 R6 R7) t=%0t sys_rst=%b/%b cpu_run=%b/%b",
                     $time, sys_rst, e_rst, cpu_run, e_run);
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic clocks(input int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   // waits until sig matches val; returns clocks waited, or -1 on timeout
   task automatic wait_for(input bit want_run, input bit val, input int limit, output int n);
      n = 0;
      while (((want_run ? cpu_run : sys_rst) !== val) && n < limit) begin
         @(negedge clk); n++;
      end
      #1;
      if (n >= limit) n = -1;
   endtask

   // watch for a sys_rst assertion over n clocks
   task automatic watch_rst(input int n, output bit seen);
      seen = 0;
      repeat (n) begin @(negedge clk); if (sys_rst) seen = 1; end
      #1;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      mismatched++;
      $display("FAIL watchdog expired (R6) actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin : stim
      int n;
      bit seen;
      #1 ext_rst_n = 0;
      clocks(20);
      chk(sys_rst === 1'b1, "R1 reset state sys_rst", sys_rst, 1);
      chk(cpu_run === 1'b0, "R1 reset state cpu_run", cpu_run, 0);
      ext_rst_n = 1;
      wait_for(1, 1, 400, n);
      chk(n >= FDV*ST && n <= FDV*ST + 8, "R6 start-up delay clocks", n, FDV*ST);

      // R8: only unselected keys held
      combo_sel = 2'd1; key_n = 4'b0011;
      watch_rst(SDV*(HT+20), seen);
      chk(!seen, "R8 unselected keys ignored", seen, 0);
      chk(cpu_run === 1'b1, "R8 cpu keeps running", cpu_run, 1);
      key_n = 4'b1111; clocks(20);

      // R8: disabled code
      combo_sel = 2'd0; key_n = 4'b0000;
      watch_rst(SDV*(HT+20), seen);
      chk(!seen, "R8 disabled code ignored", seen, 0);
      key_n = 4'b1111; clocks(20);

      // R2: subset of a three-key code
      combo_sel = 2'd2; key_n = 4'b1100;
      watch_rst(SDV*(HT+20), seen);
      chk(!seen, "R2 subset of selected keys", seen, 0);
      key_n = 4'b1111; clocks(20);

      // R2: full four-key code triggers
      combo_sel = 2'd3; key_n = 4'b0000;
      wait_for(0, 1, SDV*(HT+20), n);
      chk(n > 0, "R2 four-key combination resets", n, SDV*HT);
      key_n = 4'b1111;
      wait_for(1, 1, 1000, n);
      chk(n > 0, "R6 restart after four-key reset", n, FDV*ST);
      clocks(20);

      // R4/R3: broken hold restarts qualification
      combo_sel = 2'd1; key_n = 4'b1100;
      clocks(SDV*30);
      key_n = 4'b1101;  clocks(SDV*2);
      key_n = 4'b1100;
      wait_for(0, 1, SDV*(HT+30), n);
      chk(n >= SDV*HT - 8, "R4 glitch restarts hold count", n, SDV*HT);
      chk(n >= SDV*HT - 8 && n <= SDV*HT + 16, "R3 hold time in clocks", n, SDV*HT);

      // R5: pulse width with keys held, no retrigger
      wait_for(0, 0, SDV*PT + 20, n);
      chk(n == SDV*PT, "R5 pulse width clocks", n, SDV*PT);
      wait_for(1, 1, 400, n);
      chk(n > 0, "R5 cpu starts with keys held", n, FDV*ST);
      watch_rst(SDV*(HT+20), seen);
      chk(!seen, "R5 no retrigger while held", seen, 0);
      key_n = 4'b1111; clocks(20);

      // R7: sleep bypass
      sleep_i = 1; key_n = 4'b1100;
      wait_for(0, 1, 40, n);
      chk(n >= 0 && n <= 4*SDV, "R7 sleep latency clocks", n, 3*SDV);
      clocks(SDV*(HT+20));
      chk(sys_rst === 1'b1, "R7 held until release", sys_rst, 1);
      chk(cpu_run === 1'b0, "R6 no run while held", cpu_run, 0);
      key_n = 4'b1111;
      wait_for(0, 0, 40, n);
      chk(n >= 0 && n <= 4*SDV, "R7 release latency clocks", n, 3*SDV);
      wait_for(1, 1, 400, n);
      chk(n >= FDV*ST, "R6 start delay after bypass", n, FDV*ST);
      sleep_i = 0; clocks(20);

      // R7: oscillator-wait bypass
      osc_wait_i = 1; key_n = 4'b1100;
      wait_for(0, 1, 40, n);
      chk(n >= 0 && n <= 4*SDV, "R7 osc wait latency clocks", n, 3*SDV);
      key_n = 4'b1111; osc_wait_i = 0;
      wait_for(1, 1, 400, n);
      chk(n > 0, "R6 run after osc wait", n, FDV*ST);

      // R1: external reset mid-run
      @(negedge clk); #1 ext_rst_n = 0; #0.5;
      chk(sys_rst === 1'b1, "R1 async assert", sys_rst, 1);
      chk(cpu_run === 1'b0, "R1 run dropped", cpu_run, 0);
      clocks(10);
      ext_rst_n = 1;
      wait_for(1, 1, 400, n);
      chk(n > 0, "R6 run after external reset", n, FDV*ST);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule